// File: doc/BRIEF.md
# Banked Interleaved Vector Element Memory

This block is the word-addressed data store behind a vector load/store unit. It is split into a power-of-two number of independent banks, and the low address bits choose the bank. Every bank needs a fixed number of cycles per access. Element requests arrive one per cycle on a valid/ready channel. A request is taken at once unless its bank is still occupied by an earlier access. In that case ready stays low and the stream waits until that bank is free.

Read data come back on a response channel with a valid flag. Each response arrives a fixed number of cycles after its request was taken, so responses come out in the order the requests were accepted and no tags are needed. Writes hold their bank for the same time as reads but return nothing.

Throughput depends on the access pattern. A stride that spreads over at least as many banks as the latency streams at one element per clock. A stride that touches fewer banks leaves idle cycles. A stride that always lands in one bank delivers one element per latency period.

Top module: `vmem_top`

## Requirements
- R1: During and directly after reset, `req_ready` is high and `resp_valid` is low.
- R2: The bank is `req_addr[3:0]` and the row within the bank is `req_addr[9:4]` (16 banks, 10-bit address). A read returns the value last written to the same address. A write to one row leaves the other rows of the same bank unchanged.
- R3: A bank that accepts a request on a rising edge holds `req_ready` low for any request to that bank on the next 3 rising edges (latency 4 minus one). The bank can accept again on the 4th edge after the accepting edge.
- R4: Requests to different banks are accepted on consecutive rising edges. Sixteen unit-stride requests therefore take sixteen edges with no stall.
- R5: Each accepted read gives exactly one response. `resp_valid` is high for one cycle, starting right after the 3rd rising edge that follows the accepting edge, so it is sampled on the 4th. `resp_rdata` carries the read data. Responses keep the order of acceptance.
- R6: An accepted write occupies its bank exactly as a read does and never raises `resp_valid`.
- R7: Strided streams follow the bank occupancy. Stride 16 (same bank every time) is accepted once per 4 edges. Stride 8 alternates between two banks and stalls 2 edges out of every 4. Stride 2 cycles through 8 banks and never stalls.
- R8: While `req_valid` is low, no request is accepted and no bank becomes occupied, whatever `req_addr` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Element request present |
| req_ready | output | 1 | Target bank can take the request on this edge |
| req_addr | input | 10 | Word address of the element |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Read data valid this cycle |
| resp_rdata | output | 32 | Read data |

## Verification
Two things can happen in the same cycle: a new request is accepted, which may be a write into a bank, and an earlier read retires on the response channel. A stall on a busy bank can also fall in the same cycle as a response. The bench provokes these overlaps by sending read and write streams back to back at several strides, so acceptances, stalls and retirements overlap on nearly every cycle. A scoreboard judges the result. It keeps an independent per-bank model of when each bank is free, which predicts the edge on which each request should be accepted and the exact cycle of each response. A response with nothing queued, a late response, or a request accepted early or late is reported as a failure.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // One slot of the fixed-delay response line
    typedef struct packed {
        logic  valid;
        word_t data;
    } resp_slot_t;

endpackage

// File: rtl/vmem_bank.sv
module vmem_bank
    import vmem_pkg::*;
#(
    parameter int unsigned LATENCY = 4,
    parameter int unsigned ROW_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             we_i,
    input  logic [ROW_W-1:0] row_i,
    input  word_t            wdata_i,
    output logic             busy_o,
    output word_t            rdata_o
);

    localparam int unsigned ROWS  = 1 << ROW_W;
    localparam int unsigned CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic [CNT_W-1:0] hold;   // remaining occupied cycles after acceptance
    } bank_state_t;

    bank_state_t st_d, st_q;
    word_t       mem_q [ROWS];

    always_comb begin
        st_d = st_q;
        if (acc_i) begin
            st_d.hold = CNT_W'(LATENCY - 1);
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Storage commits at the accepting edge
    always_ff @(posedge clk) begin
        if (acc_i && we_i) begin
            mem_q[row_i] <= wdata_i;
        end
    end

    assign busy_o  = (st_q.hold != '0);
    assign rdata_o = mem_q[row_i];

    // R3: the top must never hand an access to an occupied bank
    p_accept_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |-> !busy_o);

    generate
        if (LATENCY > 1) begin : g_hold_check
            // R3: an accepted access leaves the bank occupied on the next cycle
            p_hold_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
                acc_i |=> busy_o);
        end
    endgenerate

endmodule

// File: rtl/vmem_resp_pipe.sv
module vmem_resp_pipe
    import vmem_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid_i,
    input  word_t in_data_i,
    output logic  out_valid_o,
    output word_t out_data_o
);

    resp_slot_t stage_d [DEPTH];
    resp_slot_t stage_q [DEPTH];

    always_comb begin
        stage_d[0].valid = in_valid_i;
        stage_d[0].data  = in_valid_i ? in_data_i : '0;
        for (int i = 1; i < int'(DEPTH); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign out_valid_o = stage_q[DEPTH-1].valid;
    assign out_data_o  = stage_q[DEPTH-1].data;

    // R2: a retiring read carries fully defined data
    p_known_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !$isunknown(out_data_o));

endmodule

// File: rtl/vmem_top.sv
module vmem_top
    import vmem_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 16,
    parameter int unsigned LATENCY   = 4,
    parameter int unsigned ADDR_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata
);

    localparam int unsigned BANK_W = $clog2(NUM_BANKS);
    localparam int unsigned ROW_W  = ADDR_W - BANK_W;
    localparam int unsigned FL_W   = $clog2(LATENCY + 2) + 1;

    logic [BANK_W-1:0]    sel;
    logic [ROW_W-1:0]     row;
    logic [NUM_BANKS-1:0] busy;
    logic [NUM_BANKS-1:0] acc;
    word_t                bank_rdata [NUM_BANKS];
    word_t                lane_data;
    logic                 take;
    logic                 rd_take;

    assign sel       = req_addr[BANK_W-1:0];
    assign row       = req_addr[ADDR_W-1:BANK_W];
    assign req_ready = !busy[sel];
    assign take      = req_valid && req_ready;
    assign rd_take   = take && !req_write;
    assign lane_data = bank_rdata[sel];

    generate
        for (genvar g = 0; g < int'(NUM_BANKS); g++) begin : g_bank
            assign acc[g] = take && (sel == BANK_W'(g));

            vmem_bank #(
                .LATENCY (LATENCY),
                .ROW_W   (ROW_W)
            ) i_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .acc_i   (acc[g]),
                .we_i    (req_write),
                .row_i   (row),
                .wdata_i (req_wdata),
                .busy_o  (busy[g]),
                .rdata_o (bank_rdata[g])
            );
        end
    endgenerate

    vmem_resp_pipe #(
        .DEPTH (LATENCY)
    ) i_resp_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (rd_take),
        .in_data_i   (lane_data),
        .out_valid_o (resp_valid),
        .out_data_o  (resp_rdata)
    );

    // Checker-only count of reads accepted but not yet retired
    typedef struct packed {
        logic [FL_W-1:0] cnt;
    } flight_t;

    flight_t flight_d, flight_q;

    always_comb begin
        flight_d     = flight_q;
        flight_d.cnt = flight_q.cnt + FL_W'(rd_take) - FL_W'(resp_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flight_q <= '0;
        end else begin
            flight_q <= flight_d;
        end
    end

    // R4: at most one bank takes an element per edge
    p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc));

    // R5: never more reads in flight than the latency allows
    p_inflight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flight_q.cnt <= FL_W'(LATENCY));

    // R6: a response only ever retires an accepted read
    p_write_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (flight_q.cnt != '0));

    // R3: a stall requires some occupied bank
    p_stall_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |-> (|busy));

endmodule

// File: tb/test_vmem_top.sv
module test_vmem_top;

    localparam int NB  = 16;
    localparam int LAT = 4;
    localparam int AW  = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          req_write;
    logic [31:0]   req_wdata;
    logic          resp_valid;
    logic [31:0]   resp_rdata;

    always #10 clk = ~clk;   // 50 MHz

    vmem_top #(.NUM_BANKS(NB), .LATENCY(LAT), .ADDR_W(AW)) i_vmem_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata)
    );

    typedef struct {
        int          due;
        logic [31:0] data;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] model_mem [1 << AW];
    int          last_acc [NB];
    int          cyc     = 0;
    int          checks  = 0;
    int          fails   = 0;
    bit          started = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: called at a falling edge, returns at a later falling edge with valid low
    task automatic issue(input logic [AW-1:0] a, input bit we, input logic [31:0] d, input string tag);
        int b;
        int exp_acc;
        int acc_edge;
        b         = int'(a) % NB;
        req_valid = 1'b1;
        req_addr  = a;
        req_write = we;
        req_wdata = d;
        #1;
        exp_acc = cyc + 1;
        if (last_acc[b] + LAT > exp_acc) exp_acc = last_acc[b] + LAT;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc_edge = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(acc_edge == exp_acc, tag, acc_edge, exp_acc);
        last_acc[b] = acc_edge;
        if (we) begin
            model_mem[a] = d;
        end else begin
            sb_q.push_back('{due: acc_edge + LAT - 1, data: model_mem[a]});
        end
    endtask

    task automatic drain(input string tag);
        repeat (LAT + 2) @(negedge clk);
        chk(sb_q.size() == 0, tag, sb_q.size(), 0);
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'hA500_0000 + 32'(a * 7);
    endfunction

    // Monitor: scoreboard comparison at falling edges
    always @(negedge clk) begin
        if (rst_n && started) begin
            if (resp_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 response with no read pending", resp_rdata, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(cyc == e.due, "R5 response cycle", cyc, e.due);
                    chk(resp_rdata == e.data, "R2 read data", resp_rdata, e.data);
                end
            end else if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                chk(1'b0, "R5 missing response", 0, sb_q[0].due);
                void'(sb_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) last_acc[i] = -100;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1 no response in reset", resp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1 no response after reset", resp_valid, 0);
        started = 1'b1;

        // Unit-stride writes then reads: no stall across 16 banks
        for (int a = 0; a < 16; a++) issue(AW'(a), 1'b1, pat(a), "R4 unit-stride write accept");
        for (int a = 0; a < 16; a++) issue(AW'(a), 1'b0, '0, "R4 unit-stride read accept");
        drain("R5 unit-stride responses drained");

        // Same bank, different row: stall and row independence
        issue(AW'(16), 1'b1, pat(16), "R3 write bank0 row1");
        issue(AW'(0), 1'b0, '0, "R3 same-bank read waits out latency");
        drain("R2 row independence drained");

        // Explicit busy window on bank 3
        issue(AW'(3), 1'b0, '0, "R3 read bank3");
        req_addr = AW'(19);
        for (int k = 1; k < LAT; k++) begin
            #1;
            chk(req_ready == 1'b0, "R3 bank3 ready low in busy window", req_ready, 0);
            @(negedge clk);
        end
        #1;
        chk(req_ready == 1'b1, "R3 bank3 ready again after latency", req_ready, 1);
        @(negedge clk);
        drain("R5 bank3 read drained");

        // Stride 16: single bank
        issue(AW'(32), 1'b1, pat(32), "R7 stride16 write");
        issue(AW'(48), 1'b1, pat(48), "R7 stride16 write");
        for (int a = 0; a < 64; a += 16) issue(AW'(a), 1'b0, '0, "R7 stride16 read one per latency");
        drain("R7 stride16 drained");

        // Stride 2: eight banks, no stall
        for (int a = 64; a < 96; a += 2) issue(AW'(a), 1'b1, pat(a), "R7 stride2 write no stall");
        for (int a = 64; a < 96; a += 2) issue(AW'(a), 1'b0, '0, "R7 stride2 read no stall");
        drain("R7 stride2 drained");

        // Stride 8: two banks, periodic gaps
        issue(AW'(24), 1'b1, pat(24), "R7 stride8 write");
        for (int a = 0; a < 32; a += 8) issue(AW'(a), 1'b0, '0, "R7 stride8 read with gaps");
        drain("R7 stride8 drained");

        // Valid low: nothing accepted, bank 5 stays free
        req_valid = 1'b0;
        req_addr  = AW'(5);
        req_write = 1'b1;
        req_wdata = 32'hDEAD_BEEF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(req_ready == 1'b1, "R8 idle request leaves bank free", req_ready, 1);
        end
        @(negedge clk);
        issue(AW'(5), 1'b0, '0, "R8 read after idle has no stall and old data");
        drain("R8 drained");

        // Mixed reads and writes back to back
        issue(AW'(64), 1'b0, '0, "R6 mixed read");
        issue(AW'(65), 1'b1, 32'h1234_5678, "R6 mixed write");
        issue(AW'(66), 1'b0, '0, "R6 mixed read");
        issue(AW'(81), 1'b1, 32'h0BAD_F00D, "R6 mixed write other row");
        issue(AW'(65), 1'b0, '0, "R2 read back new value");
        issue(AW'(81), 1'b0, '0, "R2 read back other row");
        drain("R6 mixed drained");

        // Read, overwrite, read the same address
        issue(AW'(100), 1'b1, 32'h5555_0001, "R2 first write");
        issue(AW'(100), 1'b0, '0, "R3 read after write same bank");
        issue(AW'(100), 1'b1, 32'h5555_0002, "R6 overwrite");
        issue(AW'(100), 1'b0, '0, "R2 read after overwrite");
        drain("R2 overwrite drained");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule